// File: doc/BRIEF.md
# Stereo Record-Path Level Controller

This block watches the stereo sample stream coming out of a record-path converter and produces a gain-reduction code. A programmable input gain stage ahead of the converter consumes that code. The louder of the two channel magnitudes is compared against two separate thresholds. The upper one, the attack level, pushes the reduction up. The lower one, the recovery level, decides whether recovery may proceed. Because the two levels are separate, the gain does not pump up and down around a single level.

Decisions are taken once per step interval. The interval is a count of valid samples, and that count is scaled by the sample-rate code so that a step lasts about the same real time at every rate. Three recovery policies are supported:
- Hold: the reduction never falls again.
- Normal: the reduction falls one step in every quiet interval until it is back at the original setting.
- Limited: recovery proceeds as in normal, but intervals that are too loud for recovery are counted. When the count reaches a programmable limit, the reduction is frozen until the next restart.

A one-cycle restart strobe clears the controller.

Top module: `alc_engine`

## Requirements
- R1: After reset, or one cycle after a restart strobe, `gain_red` is 0. Level history, the interval position, the violation count and any freeze are all cleared.
- R2: At the last sample of an interval, if any sample in that interval had a level above `atk_lvl`, `gain_red` rises by exactly 1. The level of a sample is the larger of the two channel magnitudes. The new value is visible from the clock edge that takes that sample. `gain_red` never changes except on such an interval end or on a restart.
- R3: `gain_red` saturates at its all-ones code (63 by default) and never wraps.
- R4: An interval lasts STEP_BASE valid samples for `rate_code` 0, 2×STEP_BASE for code 1, and 4×STEP_BASE for code 2. The reserved code 3 behaves as code 0.
- R5: With `rcv_mode` 0 (hold) or the reserved code 3, `gain_red` never decreases except through a restart.
- R6: With `rcv_mode` 1 (normal), an interval with no sample above `rec_lvl` lowers a non-zero `gain_red` by 1. `gain_red` never goes below 0.
- R7: An interval whose level exceeds `rec_lvl` but never exceeds `atk_lvl` leaves `gain_red` unchanged in normal mode.
- R8: With `rcv_mode` 2 (limited) and `gain_red` non-zero, an interval that exceeds `rec_lvl` without exceeding `atk_lvl` counts one violation. When the count reaches 1 << `lim_code` (1, 2, 4 or 8), `gain_red` freezes, and attack steps stop too, until a restart.
- R9: An attack step clears the violation count.
- R10: A restart strobe clears a frozen controller, after which attack steps resume.
- R11: Comparisons are strict: a level equal to a threshold does not exceed it. Negative samples count by magnitude, the most negative code included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | One-cycle synchronous restart strobe |
| in_valid | input | 1 | Sample strobe for in_left/in_right |
| in_left | input | W | Left sample, two's complement |
| in_right | input | W | Right sample, two's complement |
| atk_lvl | input | W | Attack threshold (magnitude) |
| rec_lvl | input | W | Recovery threshold (magnitude) |
| rcv_mode | input | 2 | 0 hold, 1 normal, 2 limited, 3 reserved (hold) |
| rate_code | input | 2 | Sample-rate code: 0 base, 1 double, 2 quadruple, 3 reserved |
| lim_code | input | 2 | Violation limit select, limit = 1 << lim_code |
| gain_red | output | GW | Current gain-reduction code |

## Verification
The assertions take for granted that the configuration inputs (mode, rate code, limit code and thresholds) are quasi-static. They may change only right after a restart or on an interval boundary, and `rec_lvl` is below `atk_lvl`. The stimulus respects this: it reprograms the rate code only together with a restart, and it switches the recovery policy only straight after a restart. Samples are sent one per strobe with idle cycles between them, so every interval end is a distinct clock edge.

// File: rtl/alc_engine.sv
module alc_engine #(
  parameter int W         = 16,
  parameter int GW        = 6,
  parameter int STEP_BASE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          in_valid,
  input  logic [W-1:0]  in_left,
  input  logic [W-1:0]  in_right,
  input  logic [W-1:0]  atk_lvl,
  input  logic [W-1:0]  rec_lvl,
  input  logic [1:0]    rcv_mode,
  input  logic [1:0]    rate_code,
  input  logic [1:0]    lim_code,
  output logic [GW-1:0] gain_red
);

  localparam int CW = $clog2(STEP_BASE * 4 + 1);
  localparam logic [GW-1:0] GMAX = '1;

  logic [CW-1:0] cnt_q;
  logic          over_a_q, over_r_q;
  logic [3:0]    viol_q;
  logic          lock_q;
  logic [GW-1:0] gain_q;

  wire [W-1:0] mag_l = in_left[W-1]  ? (~in_left  + 1'b1) : in_left;
  wire [W-1:0] mag_r = in_right[W-1] ? (~in_right + 1'b1) : in_right;
  wire [W-1:0] lvl   = (mag_l > mag_r) ? mag_l : mag_r;

  wire hit_a = in_valid && (lvl > atk_lvl);
  wire hit_r = in_valid && (lvl > rec_lvl);
  wire any_a = over_a_q | hit_a;
  wire any_r = over_r_q | hit_r;

  wire [CW-1:0] intv = (rate_code == 2'd1) ? CW'(STEP_BASE * 2) :
                       (rate_code == 2'd2) ? CW'(STEP_BASE * 4) :
                                             CW'(STEP_BASE);
  wire tick = in_valid && (cnt_q == intv - 1'b1);

  wire lim_mode = (rcv_mode == 2'd2);
  wire can_rcv  = (rcv_mode == 2'd1) || lim_mode;
  wire [3:0] lim  = 4'd1 << lim_code;
  wire [3:0] viol_n = viol_q + 4'd1;

  assign gain_red = gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; over_a_q <= 1'b0; over_r_q <= 1'b0;
      viol_q <= '0; lock_q <= 1'b0; gain_q <= '0;
    end else if (restart) begin
      cnt_q <= '0; over_a_q <= 1'b0; over_r_q <= 1'b0;
      viol_q <= '0; lock_q <= 1'b0; gain_q <= '0;
    end else if (in_valid) begin
      if (tick) begin
        cnt_q <= '0;
        over_a_q <= 1'b0;
        over_r_q <= 1'b0;
        if (!lock_q) begin
          if (any_a) begin
            if (gain_q != GMAX) gain_q <= gain_q + 1'b1;
            viol_q <= '0;
          end else if (can_rcv && gain_q != '0) begin
            if (any_r) begin
              if (lim_mode) begin
                viol_q <= viol_n;
                if (viol_n >= lim) lock_q <= 1'b1;
              end
            end else begin
              gain_q <= gain_q - 1'b1;
            end
          end
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        over_a_q <= any_a;
        over_r_q <= any_r;
      end
    end
  end

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> gain_red == '0);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !restart) |=> $stable(gain_red));

  // R2
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |=> (gain_red == $past(gain_red) ||
                  gain_red == $past(gain_red) + 1'b1 ||
                  gain_red == $past(gain_red) - 1'b1));

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_red == GMAX && !restart) |=> gain_red != '0);

  // R5
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (rcv_mode == 2'd0 || rcv_mode == 2'd3)) |=> gain_red >= $past(gain_red));

  // R8
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !restart) |=> $stable(gain_red));

endmodule

// File: tb/sim_alc_engine.sv
module sim_alc_engine;
  localparam int PERIOD = 10;
  localparam int W = 16, GW = 6, SB = 4;

  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0, in_valid = 1'b0;
  logic [W-1:0] in_left = '0, in_right = '0;
  logic [W-1:0] atk_lvl = 16'd1000, rec_lvl = 16'd500;
  logic [1:0] rcv_mode = 2'd1, rate_code = 2'd0, lim_code = 2'd0;
  logic [GW-1:0] gain_red;

  int checks = 0, errors = 0;
  int exp_q[$];
  string tag_q[$];
  logic mon_pend = 1'b0;

  int m_gain, m_cnt, m_viol;
  bit m_oa, m_or, m_lock;

  always #(PERIOD/2) clk = ~clk;

  alc_engine #(.W(W), .GW(GW), .STEP_BASE(SB)) u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .in_valid(in_valid),
    .in_left(in_left), .in_right(in_right), .atk_lvl(atk_lvl), .rec_lvl(rec_lvl),
    .rcv_mode(rcv_mode), .rate_code(rate_code), .lim_code(lim_code),
    .gain_red(gain_red));

  function automatic int mag(logic [W-1:0] x);
    return x[W-1] ? (65536 - int'(x)) : int'(x);
  endfunction

  function automatic void model_clear();
    m_gain = 0; m_cnt = 0; m_viol = 0; m_oa = 0; m_or = 0; m_lock = 0;
  endfunction

  function automatic void model_step(logic [W-1:0] l, logic [W-1:0] r);
    int lv, iv;
    bit oa, orr;
    lv = (mag(l) > mag(r)) ? mag(l) : mag(r);
    oa = m_oa | (lv > int'(atk_lvl));
    orr = m_or | (lv > int'(rec_lvl));
    iv = (rate_code == 1) ? SB*2 : (rate_code == 2) ? SB*4 : SB;
    if (m_cnt == iv - 1) begin
      m_cnt = 0; m_oa = 0; m_or = 0;
      if (!m_lock) begin
        if (oa) begin
          if (m_gain < 63) m_gain++;
          m_viol = 0;
        end else if ((rcv_mode == 1 || rcv_mode == 2) && m_gain != 0) begin
          if (orr) begin
            if (rcv_mode == 2) begin
              m_viol++;
              if (m_viol >= (1 << lim_code)) m_lock = 1;
            end
          end else m_gain--;
        end
      end
    end else begin
      m_cnt++; m_oa = oa; m_or = orr;
    end
  endfunction

  task automatic send(logic [W-1:0] l, logic [W-1:0] r, string tag);
    @(negedge clk);
    in_left = l; in_right = r; in_valid = 1'b1;
    model_step(l, r);
    exp_q.push_back(m_gain);
    tag_q.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic burst(int n, logic [W-1:0] l, logic [W-1:0] r, string tag);
    for (int i = 0; i < n; i++) send(l, r, tag);
  endtask

  task automatic do_restart(string tag);
    @(negedge clk);
    restart = 1'b1;
    model_clear();
    @(negedge clk);
    restart = 1'b0;
    checks++;
    if (gain_red !== 0) begin
      errors++;
      $display("FAIL %s restart: actual=%0d expected=0", tag, gain_red);
    end
  endtask

  always @(posedge clk) if (in_valid) mon_pend <= 1'b1;

  always @(negedge clk) begin
    if (mon_pend) begin
      int e;
      string t;
      mon_pend <= 1'b0;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (int'(gain_red) != e) begin
        errors++;
        $display("FAIL %s: actual=%0d expected=%0d", t, gain_red, e);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    checks++;
    if (gain_red !== 0) begin
      errors++;
      $display("FAIL R1 reset: actual=%0d expected=0", gain_red);
    end
    rst_n = 1'b1;

    rcv_mode = 2'd1;
    burst(8, 16'd2000, 16'd0, "R2 attack left");
    burst(8, 16'd0, -16'sd2000, "R11 attack negative right");
    burst(4, 16'h8000, 16'd0, "R11 most negative");
    burst(4, 16'd1000, -16'sd1000, "R11 equal threshold R7 hold");
    burst(4, 16'd700, 16'd0, "R7 hysteresis");
    burst(28, 16'd100, 16'd100, "R6 normal recovery floor");

    rate_code = 2'd1; do_restart("R1");
    burst(16, 16'd2000, 16'd0, "R4 rate code 1");
    rate_code = 2'd2; do_restart("R1");
    burst(32, 16'd2000, 16'd0, "R4 rate code 2");
    rate_code = 2'd3; do_restart("R1");
    burst(8, 16'd2000, 16'd0, "R4 reserved rate");
    rate_code = 2'd0;

    do_restart("R1");
    rcv_mode = 2'd0;
    burst(8, 16'd3000, 16'd0, "R5 hold attack");
    burst(12, 16'd10, 16'd0, "R5 hold no recovery");
    do_restart("R1");
    rcv_mode = 2'd3;
    burst(4, 16'd3000, 16'd0, "R5 reserved mode");
    burst(8, 16'd10, 16'd0, "R5 reserved no recovery");

    do_restart("R1");
    rcv_mode = 2'd0;
    burst(4 * 67, 16'd5000, 16'd5000, "R3 saturation");

    do_restart("R1");
    rcv_mode = 2'd2; lim_code = 2'd1;
    burst(12, 16'd2000, 16'd0, "R8 limited attack");
    burst(4, 16'd700, 16'd0, "R8 violation 1");
    burst(4, 16'd100, 16'd0, "R8 recover step");
    burst(4, 16'd700, 16'd0, "R8 violation 2 freeze");
    burst(8, 16'd2000, 16'd0, "R8 frozen ignores attack");
    burst(8, 16'd100, 16'd0, "R8 frozen ignores quiet");
    do_restart("R10");
    burst(4, 16'd2000, 16'd0, "R10 attack after restart");

    do_restart("R1");
    rcv_mode = 2'd2; lim_code = 2'd1;
    burst(8, 16'd2000, 16'd0, "R9 attack");
    burst(4, 16'd700, 16'd0, "R9 violation");
    burst(4, 16'd2000, 16'd0, "R9 attack clears count");
    burst(4, 16'd700, 16'd0, "R9 violation after clear");
    burst(4, 16'd100, 16'd0, "R9 still recovering");

    do_restart("R1");
    lim_code = 2'd0;
    burst(4, 16'd2000, 16'd0, "R8 limit one attack");
    burst(4, 16'd700, 16'd0, "R8 limit one freeze");
    burst(8, 16'd100, 16'd0, "R8 limit one frozen");

    lim_code = 2'd3; do_restart("R1");
    burst(16, 16'd2000, 16'd0, "R8 limit eight attack");
    burst(28, 16'd700, 16'd0, "R8 seven violations");
    burst(4, 16'd100, 16'd0, "R8 not yet frozen");
    burst(4, 16'd700, 16'd0, "R8 violation eight");
    burst(4, 16'd100, 16'd0, "R8 frozen at eight");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule